// File: doc/BRIEF.md
# Indexed Register File with Data Window

This block is the register file of a bus-attached peripheral. A 64-byte window of word-spaced locations holds sixteen 32-bit direct registers. Direct register 0 is a pointer: its low five bits select one of thirty-two 8-bit registers in a second bank. That second bank can be reached only through direct register 1, which works as a data window. Every read or write at offset 1 goes to the location that the pointer selects.

Some locations in the second bank follow their own rules:
- one always reads as zero;
- two ignore writes and keep fixed values;
- one keeps a single writable bit on top of a fixed identifier.

Among the direct registers:
- one discards every write;
- one acts as a control register, and setting its bit 0 returns the whole block to its reset state.

The bus port is synchronous. Read data is registered. The interrupt output never asserts.

Top module: `idx_regbank`

## Requirements
- R1: After hardware reset, `bus_rdata` is 0, every direct register and every indirect register reads 0, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0.
- R2: `bus_rdata` carries the addressed value on the clock edge that samples `bus_re` high, and it is 0 after any edge that samples `bus_re` low. A read in the same cycle as a write returns the contents from before that write.
- R3: The register select is `bus_addr[5:2]`, and `bus_addr[1:0]` is ignored. Direct registers 0, 3 and 5 to 15 store and return all 32 bits written.
- R4: The indirect index is bits [4:0] of direct register 0. A read at select 1 returns the indexed 8-bit register with bits [31:8] zero. A write at select 1 stores `bus_wdata[7:0]` into the indexed register.
- R5: Indirect register 3 always reads 0, even after a write to it.
- R6: Writes to indirect registers 11 and 25 have no effect. They keep reading 0x00 and 0xA0.
- R7: A write to indirect register 12 stores `(bus_wdata & 0x40) | 0x8A`.
- R8: Writes at select 2 are discarded, and select 2 always reads 0.
- R9: A write at select 4 stores `bus_wdata & 0x7F`. If `bus_wdata[0]` is 1, all other direct and indirect registers return to their R1 values in that same cycle.
- R10: `irq` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held low |

## Verification
A table of write-then-read pairs exercises each kind of location with distinct data:
- full-width patterns on plain direct registers, which tell a correct register select apart from a stuck or shifted one;
- wide values written through the window, which show whether truncation to 8 bits happens;
- all-ones and all-zeros writes to the identifier location, which separate the kept bit from the fixed bits.

Writes to the zero-read, read-only and discard locations check that nothing leaks through. Directed tests then compare control writes with and without bit 0 set. After a soft reset, they read back direct registers, the pointer and the indirect identifier values, to tell a full clear from a partial one.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   // Kind of behaviour a direct location follows
   typedef enum logic [1:0] {
      DK_PLAIN = 2'd0,
      DK_NONE  = 2'd1,
      DK_CTRL  = 2'd2
   } dir_kind_e;

   // Kind of behaviour an indirect location follows
   typedef enum logic [1:0] {
      IK_PLAIN = 2'd0,
      IK_FIXED = 2'd1,
      IK_IDENT = 2'd2
   } ind_kind_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int N_DIR    = 16,
   parameter int CTRL_IDX = 4,
   localparam int SEL_W   = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [SEL_W-1:0]  sel,
   output logic [N_DIR-1:0]  dir_we,
   output logic              soft_clr
);
   assign sel = addr[ADDR_W-1:2];

   for (genvar i = 0; i < N_DIR; i++) begin : g_we
      assign dir_we[i] = we && (sel == SEL_W'(i));
   end

   assign soft_clr = dir_we[CTRL_IDX] && wdata[0];
endmodule

// File: rtl/regbank_direct.sv
module regbank_direct
   import regbank_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                N_DIR     = 16,
   parameter int                WIN_IDX   = 1,
   parameter int                DROP_IDX  = 2,
   parameter int                CTRL_IDX  = 4,
   parameter logic [DATA_W-1:0] CTRL_MASK = DATA_W'(32'h7F)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          soft_clr,
   input  logic [N_DIR-1:0]              dir_we,
   input  logic [DATA_W-1:0]             wdata,
   output logic [N_DIR-1:0][DATA_W-1:0]  dir_q
);
   for (genvar i = 0; i < N_DIR; i++) begin : g_reg
      localparam dir_kind_e KIND = (i == WIN_IDX || i == DROP_IDX) ? DK_NONE :
                                   (i == CTRL_IDX) ? DK_CTRL : DK_PLAIN;
      if (KIND == DK_NONE) begin : g_none
         assign dir_q[i] = '0;
      end else if (KIND == DK_CTRL) begin : g_ctrl
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)         q <= '0;
            else if (dir_we[i]) q <= wdata & CTRL_MASK;
         end
         assign dir_q[i] = q;
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)         q <= '0;
            else if (soft_clr)  q <= '0;
            else if (dir_we[i]) q <= wdata;
         end
         assign dir_q[i] = q;
      end
   end
endmodule

// File: rtl/regbank_indirect.sv
module regbank_indirect
   import regbank_pkg::*;
#(
   parameter int               IND_W    = 8,
   parameter int               N_IND    = 32,
   parameter int               RAZ_IDX  = 3,
   parameter int               RO_A_IDX = 11,
   parameter int               RO_B_IDX = 25,
   parameter int               ID_IDX   = 12,
   parameter logic [IND_W-1:0] ID_VAL   = 8'h8A,
   parameter logic [IND_W-1:0] ID_KEEP  = 8'h40,
   parameter logic [IND_W-1:0] VER_VAL  = 8'hA0,
   localparam int              IDX_W    = $clog2(N_IND)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic             win_we,
   input  logic [IDX_W-1:0] idx,
   input  logic [IND_W-1:0] wdata,
   output logic [IND_W-1:0] rd_byte
);
   logic [N_IND-1:0][IND_W-1:0] loc_q;

   for (genvar i = 0; i < N_IND; i++) begin : g_loc
      localparam logic [IND_W-1:0] RST = (i == ID_IDX)   ? ID_VAL  :
                                         (i == RO_B_IDX) ? VER_VAL : '0;
      localparam ind_kind_e KIND = (i == RO_A_IDX || i == RO_B_IDX) ? IK_FIXED :
                                   (i == ID_IDX) ? IK_IDENT : IK_PLAIN;
      if (KIND == IK_FIXED) begin : g_fixed
         assign loc_q[i] = RST;
      end else begin : g_rw
         logic [IND_W-1:0] q;
         logic [IND_W-1:0] nxt;
         logic             hit;
         assign hit = win_we && (idx == IDX_W'(i));
         if (KIND == IK_IDENT) begin : g_id
            assign nxt = (wdata & ID_KEEP) | ID_VAL;
         end else begin : g_pl
            assign nxt = wdata;
         end
         always_ff @(posedge clk) begin
            if (!rst_n)        q <= RST;
            else if (soft_clr) q <= RST;
            else if (hit)      q <= nxt;
         end
         assign loc_q[i] = q;
      end
   end

   assign rd_byte = (idx == IDX_W'(RAZ_IDX)) ? '0 : loc_q[idx];
endmodule

// File: rtl/idx_regbank.sv
module idx_regbank #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int N_DIR  = 16,
   parameter int IND_W  = 8,
   parameter int N_IND  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int SEL_W    = ADDR_W - 2;
   localparam int IDX_W    = $clog2(N_IND);
   localparam int PTR_IDX  = 0;
   localparam int WIN_IDX  = 1;
   localparam int DROP_IDX = 2;
   localparam int CTRL_IDX = 4;

   if (N_DIR != (1 << SEL_W)) begin : g_bad_dir
      $error("N_DIR must fill the address window");
   end
   if (IND_W > DATA_W || IDX_W > DATA_W) begin : g_bad_w
      $error("indirect width or index exceeds data width");
   end
   if (N_IND != (1 << IDX_W)) begin : g_bad_ind
      $error("N_IND must be a power of two");
   end

   logic [SEL_W-1:0]             sel;
   logic [N_DIR-1:0]             dir_we;
   logic                         soft_clr;
   logic [N_DIR-1:0][DATA_W-1:0] dir_q;
   logic [IND_W-1:0]             ind_rd;
   logic [IDX_W-1:0]             ind_idx;
   logic [DATA_W-1:0]            rd_mux;

   regbank_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_DIR(N_DIR),
                    .CTRL_IDX(CTRL_IDX)) u_dec (
      .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .sel(sel), .dir_we(dir_we), .soft_clr(soft_clr));

   regbank_direct #(.DATA_W(DATA_W), .N_DIR(N_DIR), .WIN_IDX(WIN_IDX),
                    .DROP_IDX(DROP_IDX), .CTRL_IDX(CTRL_IDX)) u_dir (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .dir_we(dir_we),
      .wdata(bus_wdata), .dir_q(dir_q));

   assign ind_idx = dir_q[PTR_IDX][IDX_W-1:0];

   regbank_indirect #(.IND_W(IND_W), .N_IND(N_IND)) u_ind (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
      .win_we(dir_we[WIN_IDX]), .idx(ind_idx),
      .wdata(bus_wdata[IND_W-1:0]), .rd_byte(ind_rd));

   assign rd_mux = (sel == SEL_W'(WIN_IDX)) ? DATA_W'(ind_rd) : dir_q[sel];

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   assign irq = 1'b0;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [IDX_W-1:0]  ind_idx
);
   logic [ADDR_W-3:0] sel;
   assign sel = bus_addr[ADDR_W-1:2];

   // R10
   irq_low_chk: assert property (@(posedge clk) !irq);

   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> bus_rdata == '0);

   // R8
   drop_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == 2) |=> bus_rdata == '0);

   // R4
   window_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == 1) |=> bus_rdata[DATA_W-1:8] == '0);

   // R5
   raz_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == 1 && ind_idx == 3) |=> bus_rdata == '0);

   // R6
   version_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == 1 && ind_idx == 25) |=> bus_rdata == DATA_W'(8'hA0));

   // R7
   ident_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == 1 && ind_idx == 12) |=>
         (bus_rdata | DATA_W'(8'h40)) == DATA_W'(8'hCA));

   // R9
   ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && sel == 4) |=> bus_rdata[DATA_W-1:7] == '0);
endmodule

bind idx_regbank regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_re(bus_re),
   .bus_rdata(bus_rdata), .irq(irq), .ind_idx(ind_idx));

// File: tb/idx_regbank_test.sv
`timescale 1ns/1ps
module idx_regbank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   idx_regbank uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
                    .irq(irq));

   // {addr, write data, expected read-back, requirement number}
   localparam logic [73:0] VEC [16] = '{
      {6'h00, 32'hABCD_E00C, 32'hABCD_E00C, 4'd3},  // R3 pointer -> 12
      {6'h04, 32'h0000_00FF, 32'h0000_00CA, 4'd7},  // R7 kept bit set
      {6'h04, 32'h0000_0000, 32'h0000_008A, 4'd7},  // R7 kept bit clear
      {6'h00, 32'h0000_0003, 32'h0000_0003, 4'd4},  // R4 pointer -> 3
      {6'h04, 32'h0000_005A, 32'h0000_0000, 4'd5},  // R5 reads zero
      {6'h00, 32'h0000_000B, 32'h0000_000B, 4'd4},  // pointer -> 11
      {6'h04, 32'h0000_0077, 32'h0000_0000, 4'd6},  // R6 fixed 0
      {6'h00, 32'h0000_0019, 32'h0000_0019, 4'd4},  // pointer -> 25
      {6'h04, 32'h0000_0055, 32'h0000_00A0, 4'd6},  // R6 fixed A0
      {6'h00, 32'hFFFF_FF07, 32'hFFFF_FF07, 4'd4},  // pointer low 5 bits -> 7
      {6'h04, 32'h1234_5678, 32'h0000_0078, 4'd4},  // R4 truncation
      {6'h08, 32'hDEAD_BEEF, 32'h0000_0000, 4'd8},  // R8 discarded
      {6'h0F, 32'hCAFE_F00D, 32'hCAFE_F00D, 4'd3},  // R3 low bits ignored
      {6'h3C, 32'h8000_0001, 32'h8000_0001, 4'd3},  // R3 last register
      {6'h10, 32'hFFFF_FF80, 32'h0000_0000, 4'd9},  // R9 mask, no clear
      {6'h10, 32'h0000_007E, 32'h0000_007E, 4'd9}   // R9 mask
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      d = bus_rdata;
      bus_re = 1'b0;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata", bus_rdata, 32'h0);
      check("R10 irq", {31'b0, irq}, 32'h0);
      rd(6'h00, v); check("R1 reg0", v, 32'h0);
      rd(6'h3C, v); check("R1 reg15", v, 32'h0);
      rd(6'h04, v); check("R1 ind0", v, 32'h0);
      wr(6'h00, 32'd12); rd(6'h04, v); check("R1 ind12", v, 32'h8A);
      wr(6'h00, 32'd25); rd(6'h04, v); check("R1 ind25", v, 32'hA0);

      for (int i = 0; i < 16; i++) begin
         wr(VEC[i][73:68], VEC[i][67:36]);
         rd(VEC[i][73:68], v);
         checks++;
         if (v !== VEC[i][35:4]) begin
            failures++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][3:0], i, v, VEC[i][35:4]);
         end
         check("R10 irq", {31'b0, irq}, 32'h0);
      end

      // R2: registered timing and zero when idle
      @(negedge clk);
      bus_addr = 6'h3C; bus_re = 1'b1;
      @(negedge clk);
      check("R2 latency", bus_rdata, 32'h8000_0001);
      bus_re = 1'b0;
      @(negedge clk);
      check("R2 idle zero", bus_rdata, 32'h0);
      // R2: same-cycle read and write returns old value
      @(negedge clk);
      bus_addr = 6'h14; bus_wdata = 32'h1111_2222; bus_we = 1'b1; bus_re = 1'b1;
      @(negedge clk);
      check("R2 read-before-write", bus_rdata, 32'h0);
      bus_we = 1'b0; bus_re = 1'b0;
      rd(6'h14, v); check("R2 write landed", v, 32'h1111_2222);

      // R9: earlier control writes with bit 0 clear kept other state
      rd(6'h0C, v); check("R9 no clear reg3", v, 32'hCAFE_F00D);
      rd(6'h04, v); check("R9 no clear ind7", v, 32'h78);

      // R9: soft reset
      wr(6'h10, 32'hFFFF_FFFF);
      rd(6'h10, v); check("R9 ctrl value", v, 32'h7F);
      rd(6'h00, v); check("R9 pointer cleared", v, 32'h0);
      rd(6'h0C, v); check("R9 reg3 cleared", v, 32'h0);
      rd(6'h3C, v); check("R9 reg15 cleared", v, 32'h0);
      wr(6'h00, 32'd7);  rd(6'h04, v); check("R9 ind7 cleared", v, 32'h0);
      wr(6'h00, 32'd12); rd(6'h04, v); check("R9 ind12 restored", v, 32'h8A);
      wr(6'h00, 32'd25); rd(6'h04, v); check("R9 ind25 kept", v, 32'hA0);
      check("R10 irq", {31'b0, irq}, 32'h0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule